// File: doc/BRIEF.md
# Page Buffer and Self-Timed Write Controller

This block sits behind the serial front end of a small non-volatile memory. A write command opens with a start pulse that loads the address pointer. Each data byte the front end receives then goes into a page latch with one entry per byte of a page, and only the low page-offset bits of the pointer step forward. When the closing stop pulse arrives after at least one data byte, and the write-protect input is low at that moment, the controller copies the entries marked dirty into the memory array. The array is modelled as an on-chip synchronous RAM, and the copy runs over a programming interval of fixed length.

During that interval `busy` is high. The front end uses it to withhold acknowledges, and the controller ignores every command input while it lasts. If write-protect is high at stop, the array is left untouched, no interval follows, and the next command is taken at once. A registered read port gives the front end, and the bench, access to the array contents. The pointer output always holds the address that follows the last byte latched, kept inside the current page.

Top module: `page_prog_ctrl`

## Requirements
- R1: After synchronous reset, `busy` is 0 and `ptr` is 0.
- R2: A data byte accepted during an open command goes into the latch entry selected by `ptr[PAGE_W-1:0]`. The low PAGE_W bits of `ptr` then increment modulo 2^PAGE_W, and the upper bits keep the value loaded at start. After a one-byte write to address A, `ptr` is {A upper bits, A low bits + 1}.
- R3: When more than 2^PAGE_W bytes (64 by default) arrive in one command, the offset wraps. A later byte overwrites the earlier byte at the same offset, and only the last value at each offset is committed.
- R4: No array location changes while a command is open and before its stop. A stop with no data byte since the start causes no busy interval.
- R5: At a stop with write-protect low, every latch entry written in this command is stored at {ptr upper bits, offset}. Locations of the page that were not written in this command keep their contents. Dirty marks clear at each accepted start.
- R6: Write-protect is sampled in the stop cycle. When it is high, no array location changes, `busy` stays 0, and a start in the very next cycle is accepted.
- R7: Changing write-protect after the stop does not affect a commit already in progress.
- R8: `busy` rises in the cycle after an accepted stop and stays high for exactly max(PROG_CYCLES, 2^PAGE_W) cycles.
- R9: While `busy` is high, `wr_start`, `byte_vld` and `stop_pulse` are ignored: `ptr` and the array do not change because of them.
- R10: `rd_data` presents the array byte at `rd_addr` one clock after `rd_addr` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_start | input | 1 | One-cycle pulse: a write command opens |
| start_addr | input | ADDR_W | Address loaded into the pointer at start |
| byte_vld | input | 1 | One-cycle pulse: a data byte is present |
| byte_data | input | DATA_W | Received data byte |
| stop_pulse | input | 1 | One-cycle pulse: the command closes |
| wp | input | 1 | Write-protect, sampled at stop |
| busy | output | 1 | Programming interval in progress |
| ptr | output | ADDR_W | Current address pointer |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | DATA_W | Registered array read data |

## Verification
The assertions assume that `wr_start`, `byte_vld` and `stop_pulse` are single-cycle pulses and that no two of them are high in the same cycle. They also assume that reset is held from time zero until the first clock edges, so the pointer starts from a known value. The bench drives every pulse for exactly one cycle from the falling clock edge and issues them one at a time. The one deliberate exception is the burst of pulses sent while `busy` is high, which tests that those inputs are ignored.

// File: rtl/ppc_pkg.sv
package ppc_pkg;
  // Programming interval length: never shorter than one slot per latch entry.
  function automatic int eff_cycles(input int prog, input int page_w);
    int slots;
    slots = 1 << page_w;
    return (prog < slots) ? slots : prog;
  endfunction
endpackage

// File: rtl/ppc_page_latch.sv
module ppc_page_latch #(
  parameter int DATA_W = 8,
  parameter int PAGE_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_dirty,
  input  logic              wr_en,
  input  logic [PAGE_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [PAGE_W-1:0] rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_dirty
);
  localparam int SLOTS = 1 << PAGE_W;

  logic [DATA_W-1:0] store [SLOTS];
  logic [SLOTS-1:0]  dirty;

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_idx] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr_dirty) dirty <= '0;
    else if (wr_en)       dirty[wr_idx] <= 1'b1;
  end

  assign rd_data  = store[rd_idx];
  assign rd_dirty = dirty[rd_idx];
endmodule

// File: rtl/ppc_prog_timer.sv
module ppc_prog_timer #(
  parameter int PROG_CYCLES = 64,
  parameter int PAGE_W      = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  output logic              busy,
  output logic              slot_en,
  output logic [PAGE_W-1:0] slot_idx
);
  localparam int EFF   = ppc_pkg::eff_cycles(PROG_CYCLES, PAGE_W);
  localparam int CW    = $clog2(EFF + 1);
  localparam int SLOTS = 1 << PAGE_W;

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (!busy) begin
      if (launch) begin
        busy <= 1'b1;
        cnt  <= '0;
      end
    end else if (cnt == CW'(EFF - 1)) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign slot_idx = cnt[PAGE_W-1:0];
  assign slot_en  = busy && (cnt < CW'(SLOTS));
endmodule

// File: rtl/ppc_array.sv
module ppc_array #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/page_prog_ctrl.sv
module page_prog_ctrl #(
  parameter int ADDR_W      = 11,
  parameter int DATA_W      = 8,
  parameter int PAGE_W      = 6,
  parameter int PROG_CYCLES = 1250000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              byte_vld,
  input  logic [DATA_W-1:0] byte_data,
  input  logic              stop_pulse,
  input  logic              wp,
  output logic              busy,
  output logic [ADDR_W-1:0] ptr,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int HI_W = ADDR_W - PAGE_W;

  logic              cmd_active;
  logic              got_byte;
  logic              take_start;
  logic              take_byte;
  logic              take_stop;
  logic              launch;
  logic              slot_en;
  logic [PAGE_W-1:0] slot_idx;
  logic [DATA_W-1:0] slot_data;
  logic              slot_dirty;
  logic [HI_W-1:0]   page_hi;

  // Command decode: inputs count only while idle; start outranks byte outranks stop.
  assign take_start = !busy && wr_start;
  assign take_byte  = !busy && !wr_start && cmd_active && byte_vld;
  assign take_stop  = !busy && !wr_start && !byte_vld && cmd_active && stop_pulse;
  assign launch     = take_stop && got_byte && !wp;
  assign page_hi    = ptr[ADDR_W-1:PAGE_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr        <= '0;
      cmd_active <= 1'b0;
      got_byte   <= 1'b0;
    end else if (take_start) begin
      ptr        <= start_addr;
      cmd_active <= 1'b1;
      got_byte   <= 1'b0;
    end else if (take_byte) begin
      ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
      got_byte        <= 1'b1;
    end else if (take_stop) begin
      cmd_active <= 1'b0;
      got_byte   <= 1'b0;
    end
  end

  ppc_page_latch #(.DATA_W(DATA_W), .PAGE_W(PAGE_W)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .clr_dirty(take_start),
    .wr_en    (take_byte),
    .wr_idx   (ptr[PAGE_W-1:0]),
    .wr_data  (byte_data),
    .rd_idx   (slot_idx),
    .rd_data  (slot_data),
    .rd_dirty (slot_dirty)
  );

  ppc_prog_timer #(.PROG_CYCLES(PROG_CYCLES), .PAGE_W(PAGE_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .launch  (launch),
    .busy    (busy),
    .slot_en (slot_en),
    .slot_idx(slot_idx)
  );

  ppc_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .clk  (clk),
    .we   (slot_en && slot_dirty),
    .waddr({page_hi, slot_idx}),
    .wdata(slot_data),
    .raddr(rd_addr),
    .rdata(rd_data)
  );
endmodule

// File: rtl/page_prog_ctrl_chk.sv
module page_prog_ctrl_chk #(
  parameter int ADDR_W      = 11,
  parameter int PAGE_W      = 6,
  parameter int PROG_CYCLES = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_start,
  input logic              byte_vld,
  input logic              stop_pulse,
  input logic              wp,
  input logic              busy,
  input logic              cmd_active,
  input logic [ADDR_W-1:0] ptr
);
  localparam int EFF = ppc_pkg::eff_cycles(PROG_CYCLES, PAGE_W);
  localparam int RW  = $clog2(EFF + 2);

  logic [RW-1:0] run_len;

  always_ff @(posedge clk) begin
    if (rst)       run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  assert_busy_len_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> run_len == RW'(EFF));

  assert_busy_from_stop_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(stop_pulse && !wp));

  assert_wp_no_busy_R6: assert property (@(posedge clk) disable iff (rst)
    (stop_pulse && wp && !busy) |=> !busy);

  assert_page_fixed_R2: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_start) |-> $stable(ptr[ADDR_W-1:PAGE_W]));

  assert_offset_step_R2: assert property (@(posedge clk) disable iff (rst)
    (byte_vld && cmd_active && !busy && !wr_start)
      |=> ptr[PAGE_W-1:0] == PAGE_W'($past(ptr[PAGE_W-1:0]) + 1'b1));

  assert_ptr_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(ptr));
endmodule

bind page_prog_ctrl page_prog_ctrl_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .PROG_CYCLES(PROG_CYCLES)
) u_chk (
  .clk(clk), .rst(rst), .wr_start(wr_start), .byte_vld(byte_vld),
  .stop_pulse(stop_pulse), .wp(wp), .busy(busy), .cmd_active(cmd_active),
  .ptr(ptr)
);

// File: tb/page_prog_ctrl_bench.sv
module page_prog_ctrl_bench;
  localparam int AW   = 11;
  localparam int DW   = 8;
  localparam int PW   = 6;
  localparam int PROG = 80;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_start = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic          byte_vld = 1'b0;
  logic [DW-1:0] byte_data = '0;
  logic          stop_pulse = 1'b0;
  logic          wp = 1'b0;
  logic          busy;
  logic [AW-1:0] ptr;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;

  always #2 clk = ~clk;

  page_prog_ctrl #(.ADDR_W(AW), .DATA_W(DW), .PAGE_W(PW), .PROG_CYCLES(PROG)) u_page_prog_ctrl (
    .clk(clk), .rst(rst), .wr_start(wr_start), .start_addr(start_addr),
    .byte_vld(byte_vld), .byte_data(byte_data), .stop_pulse(stop_pulse),
    .wp(wp), .busy(busy), .ptr(ptr), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // Bench model of the requirements
  logic [DW-1:0] model [1 << AW];
  bit            known [1 << AW];
  logic [DW-1:0] b_lat [1 << PW];
  bit            b_dirty [1 << PW];
  logic [AW-1:0] b_ptr;
  bit            b_act, b_got, exp_commit;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  // {addr[10:0], count[6:0], seed[7:0], wp}
  localparam logic [26:0] VEC [7] = '{
    {11'h040, 7'd1,  8'h11, 1'b0},
    {11'h07E, 7'd4,  8'h22, 1'b0},
    {11'h100, 7'd64, 8'h33, 1'b0},
    {11'h205, 7'd70, 8'h44, 1'b0},
    {11'h300, 7'd8,  8'h77, 1'b0},
    {11'h302, 7'd3,  8'h55, 1'b1},
    {11'h3C0, 7'd5,  8'h66, 1'b0}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic start_cmd(input logic [AW-1:0] a);
    wr_start = 1'b1; start_addr = a;
    tick();
    wr_start = 1'b0;
    b_ptr = a; b_act = 1'b1; b_got = 1'b0;
    for (int i = 0; i < (1 << PW); i++) b_dirty[i] = 1'b0;
  endtask

  task automatic send_byte(input logic [DW-1:0] d);
    byte_vld = 1'b1; byte_data = d;
    tick();
    byte_vld = 1'b0;
    b_lat[b_ptr[PW-1:0]] = d;
    b_dirty[b_ptr[PW-1:0]] = 1'b1;
    b_ptr[PW-1:0] = b_ptr[PW-1:0] + 1'b1;
    b_got = 1'b1;
  endtask

  task automatic stop_cmd(input bit w);
    wp = w; stop_pulse = 1'b1;
    tick();
    stop_pulse = 1'b0;
    exp_commit = b_act && b_got && !w;
    if (exp_commit)
      for (int i = 0; i < (1 << PW); i++)
        if (b_dirty[i]) begin
          model[{b_ptr[AW-1:PW], PW'(i)}] = b_lat[i];
          known[{b_ptr[AW-1:PW], PW'(i)}] = 1'b1;
        end
    b_act = 1'b0; b_got = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    int n = 0;
    while (busy && n < 4 * PROG) begin n++; tick(); end
    chk(n == PROG, tag, n, PROG);
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input string tag);
    rd_addr = a;
    tick();
    if (known[a]) chk(rd_data == model[a], tag, rd_data, model[a]);
  endtask

  task automatic rd_page(input logic [AW-1:0] a, input string tag);
    for (int i = 0; i < (1 << PW); i++) rd_chk({a[AW-1:PW], PW'(i)}, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < (1 << AW); i++) known[i] = 1'b0;
    b_act = 1'b0; b_got = 1'b0; b_ptr = '0;
    repeat (3) tick();
    // R1: reset state
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(ptr == '0, "R1 ptr", ptr, 0);
    rst = 1'b0;
    tick();

    // Vector table walk
    for (int v = 0; v < 7; v++) begin
      logic [AW-1:0] a;
      logic [6:0]    n;
      logic [7:0]    s;
      logic          w;
      string         tg;
      {a, n, s, w} = VEC[v];
      start_cmd(a);
      for (int i = 0; i < int'(n); i++) send_byte(8'(s + i * 13));
      chk(ptr == b_ptr, "R2 pointer after bytes", ptr, b_ptr);
      stop_cmd(w);
      if (exp_commit) begin
        chk(busy == 1'b1, "R8 busy rise", busy, 1);
        wait_idle("R8 busy length");
      end else begin
        chk(busy == 1'b0, "R6 no busy when protected", busy, 0);
      end
      tg = (n > 7'd64) ? "R3 wrap overwrite" : (w ? "R6 protected page" : "R5 commit");
      rd_page(a, tg);
    end

    // R4: array unchanged before stop; empty command gives no busy
    start_cmd(11'h040);
    send_byte(8'hA5);
    rd_chk(11'h040, "R4 before stop");
    stop_cmd(1'b0);
    wait_idle("R8 busy length");
    rd_chk(11'h040, "R5 byte write");
    start_cmd(11'h050);
    stop_cmd(1'b0);
    chk(busy == 1'b0, "R4 empty command", busy, 0);

    // R6: protected stop, then a start in the very next cycle is taken
    start_cmd(11'h300);
    send_byte(8'h01);
    stop_cmd(1'b1);
    start_cmd(11'h313);
    chk(ptr == 11'h313, "R6 immediate accept", ptr, 11'h313);
    send_byte(8'h9C);
    stop_cmd(1'b0);
    wait_idle("R8 busy length");
    rd_chk(11'h300, "R6 protected byte");
    rd_chk(11'h313, "R6 next command");

    // R5: dirty marks cleared at start; stale latch data not committed
    start_cmd(11'h100);
    for (int i = 0; i < 4; i++) send_byte(8'hD0 + 8'(i));
    stop_cmd(1'b1);
    start_cmd(11'h10A);
    send_byte(8'h5A);
    chk(ptr == 11'h10B, "R2 byte write pointer", ptr, 11'h10B);
    stop_cmd(1'b0);
    wait_idle("R8 busy length");
    rd_page(11'h100, "R5 dirty only");

    // R7: wp raised during busy does not abort; R9: inputs ignored while busy
    start_cmd(11'h4F0);
    send_byte(8'h3E);
    send_byte(8'h3F);
    stop_cmd(1'b0);
    wp = 1'b1;
    wr_start = 1'b1; start_addr = 11'h3C2; tick(); wr_start = 1'b0;
    byte_vld = 1'b1; byte_data = 8'hEE; tick(); byte_vld = 1'b0;
    stop_pulse = 1'b1; tick(); stop_pulse = 1'b0;
    chk(ptr == 11'h4F2, "R9 ptr held", ptr, 11'h4F2);
    while (busy) tick();
    wp = 1'b0;
    rd_chk(11'h4F0, "R7 commit despite wp");
    rd_chk(11'h4F1, "R7 commit despite wp");
    rd_chk(11'h3C2, "R9 ignored write");
    chk(ptr == 11'h4F2, "R9 ptr after busy", ptr, 11'h4F2);

    // R10: read latency one clock
    rd_addr = 11'h4F1;
    tick();
    rd_addr = 11'h040;
    #1;
    chk(rd_data == model[11'h4F1], "R10 read latency", rd_data, model[11'h4F1]);
    tick();
    chk(rd_data == model[11'h040], "R10 read latency", rd_data, model[11'h040]);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule